// File: doc/BRIEF.md
# Buffered Factory Program Sequencer

This block is the device-side sequencer for a bulk word-programming mode of a NOR-style flash array. A host writes address and data through a single write port. The sequencer recognises a two-write entry sequence and waits through a fixed setup delay. At the end of that delay it checks the programming-voltage flag and the lock flag of the target block. It then collects full buffers of words, and it programs each full buffer into consecutive array locations through a request/acknowledge array write port.

Once the mode is active, the sequencer takes every host write as buffer data or as an exit or abort event. It decodes no commands in this phase. Reads aimed at the target block return the 8-bit status instead of array contents. The internal array pointer starts at the entry address and carries on from one buffer to the next. The host leaves the mode by writing the all-ones word to any address outside the target block.

Top module: `bfp_seq`

## Requirements
- R1: Out of reset, status reads 80h (bit 7 = ready/idle, all other bits 0) and the array request is low.
- R2: A write whose low data byte is 80h, followed by a write whose low data byte is D0h to an address in the same block with its low log2(BUF_WORDS) bits zero, enters the mode. Status then reads 01h (bit 7 = 0, bit 0 = busy) for exactly SETUP_CYC cycles. After that it reads 00h when both setup checks pass.
- R3: If the second write of the entry is not D0h, is misaligned, or lies in another block, the sequencer returns to idle with program-fail bit 4 set (status 90h).
- R4: At the end of the setup delay, a low vpp_ok sets bit 3 and a high blk_locked sets bit 1. Either error returns the sequencer to idle with bit 7 set (88h, 82h, or 8Ah for both).
- R5: While the mode is active, host_rdata returns {zeros, status} for a read address in the target block. In every other case host_rdata passes arr_rdata through.
- R6: An aligned in-block write while the buffer accepts data fills slots 0, 1, 2 and onward in order. Any data value is stored, including 70h. The write that fills the last slot raises status bit 0.
- R7: A full buffer is issued on the array port in slot order, one word per acknowledged request, at consecutive addresses that start at the entry address. Address and data hold while a request waits. Bit 0 falls once the last word is acknowledged.
- R8: The array pointer continues across buffers: the first word of a buffer goes to the address after the last word of the previous buffer.
- R9: While the buffer accepts data, an in-block misaligned write, or an out-of-block write whose data is not FFFFh, returns to idle with bit 4 set. The partly filled buffer is never issued to the array.
- R10: While the buffer accepts data, writing FFFFh to an address outside the target block returns to idle with status 80h.
- R11: If a buffer completes after the pointer has passed the last word of the block, it is discarded and the sequencer returns to idle with bit 4 set.
- R12: An accepted 80h entry write clears the error bits, so status reads 80h after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | ADDR_W | Host write word address |
| host_wdata | input | DATA_W | Host write data |
| host_raddr | input | ADDR_W | Host read word address |
| host_rdata | output | DATA_W | Read data: status or array data |
| vpp_ok | input | 1 | Programming voltage is good |
| blk_locked | input | 1 | Target block is locked |
| status | output | 8 | Status register |
| arr_req | output | 1 | Array word write request |
| arr_addr | output | ADDR_W | Array word address |
| arr_data | output | DATA_W | Array word data |
| arr_ack | input | 1 | Array word write done |
| arr_rdata | input | DATA_W | Array read data |

## Verification
The assertions assume that arr_ack is raised only while arr_req is high, and that vpp_ok and blk_locked are already settled when the setup delay ends. They also take each host write as a single-cycle strobe that is sampled on one edge. The bench drives all inputs on the falling edge and holds the write strobe for exactly one cycle. Its array model raises the acknowledge only in answer to a request, on alternate cycles, which also exercises the waiting state. Before it loads the next buffer, it waits for longer than the programming time of a full buffer.

// File: rtl/bfp_pkg.sv
package bfp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARMED,
      ST_SETUP,
      ST_FILL,
      ST_PROG
   } bfp_state_e;

   localparam logic [7:0] CMD_ENTER   = 8'h80;
   localparam logic [7:0] CMD_CONFIRM = 8'hD0;

endpackage

// File: rtl/bfp_addr_chk.sv
module bfp_addr_chk #(
   parameter int ADDR_W    = 24,
   parameter int BLK_WORDS = 65536,
   parameter int BUF_WORDS = 32,
   localparam int BLK_AW   = $clog2(BLK_WORDS),
   localparam int BUF_AW   = $clog2(BUF_WORDS),
   localparam int BN_W     = ADDR_W - BLK_AW
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [BN_W-1:0]   blk_ref,
   output logic              hit,
   output logic              aligned,
   output logic [BLK_AW-1:0] offs,
   output logic [BN_W-1:0]   bnum
);

   assign bnum    = addr[ADDR_W-1:BLK_AW];
   assign offs    = addr[BLK_AW-1:0];
   assign hit     = (bnum == blk_ref);
   assign aligned = (addr[BUF_AW-1:0] == '0);

endmodule

// File: rtl/bfp_setup_tmr.sv
module bfp_setup_tmr #(
   parameter int SETUP_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);

   generate
      if (SETUP_CYC <= 1) begin : g_nodly
         assign done = run;
      end else begin : g_cnt
         localparam int CW = $clog2(SETUP_CYC);
         logic [CW-1:0] cnt_q;

         assign done = run && (cnt_q == CW'(SETUP_CYC - 1));

         always_ff @(posedge clk) begin
            if (!rst_n)     cnt_q <= '0;
            else if (!run)  cnt_q <= '0;
            else if (!done) cnt_q <= cnt_q + 1'b1;
         end

         // R2
         dly_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (run && !done) |=> (cnt_q != '0 || !run));
      end
   endgenerate

endmodule

// File: rtl/bfp_wbuf.sv
module bfp_wbuf #(
   parameter int DATA_W    = 16,
   parameter int BUF_WORDS = 32,
   localparam int IDX_W    = $clog2(BUF_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              last
);

   logic [IDX_W-1:0]  cnt_q;
   logic [DATA_W-1:0] slot_q [BUF_WORDS];

   for (genvar g = 0; g < BUF_WORDS; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (wr_en && cnt_q == IDX_W'(g)) slot_q[g] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr)   cnt_q <= '0;
      else if (wr_en) cnt_q <= cnt_q + 1'b1;
   end

   assign last    = (cnt_q == IDX_W'(BUF_WORDS - 1));
   assign rd_data = slot_q[rd_idx];

   // R6
   fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/bfp_seq.sv
module bfp_seq
   import bfp_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int DATA_W    = 16,
   parameter int BUF_WORDS = 32,
   parameter int BLK_WORDS = 65536,
   parameter int SETUP_CYC = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [ADDR_W-1:0] host_raddr,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              vpp_ok,
   input  logic              blk_locked,
   output logic [7:0]        status,
   output logic              arr_req,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] arr_data,
   input  logic              arr_ack,
   input  logic [DATA_W-1:0] arr_rdata
);

   localparam int BLK_AW = $clog2(BLK_WORDS);
   localparam int BUF_AW = $clog2(BUF_WORDS);
   localparam int BN_W   = ADDR_W - BLK_AW;
   localparam logic [BUF_AW-1:0] IDX_LAST = BUF_AW'(BUF_WORDS - 1);

   // elaboration-time parameter checks
   if (BUF_WORDS < 2 || (BUF_WORDS & (BUF_WORDS - 1)) != 0) begin : g_bad_buf
      $error("BUF_WORDS must be a power of two of at least 2");
   end
   if (BLK_WORDS < BUF_WORDS || (BLK_WORDS & (BLK_WORDS - 1)) != 0) begin : g_bad_blk
      $error("BLK_WORDS must be a power of two not below BUF_WORDS");
   end
   if (ADDR_W <= BLK_AW) begin : g_bad_addr
      $error("ADDR_W must exceed the block offset width");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("DATA_W must hold the 8-bit status");
   end

   bfp_state_e        st_q, st_d;
   logic [BN_W-1:0]   blk_q, blk_d;
   logic [BLK_AW:0]   ptr_q, ptr_d;
   logic [BUF_AW-1:0] idx_q, idx_d;
   logic              pf_q, pf_d, verr_q, verr_d, lerr_q, lerr_d;

   logic              wa_hit, wa_al;
   logic [BLK_AW-1:0] wa_offs;
   logic [BN_W-1:0]   wa_bnum;
   logic              tmr_done;
   logic              buf_last, buf_wr;
   logic [DATA_W-1:0] buf_rd;
   logic              mode_on, rd_hit;

   bfp_addr_chk #(
      .ADDR_W   (ADDR_W),
      .BLK_WORDS(BLK_WORDS),
      .BUF_WORDS(BUF_WORDS)
   ) u_wchk (
      .addr   (host_addr),
      .blk_ref(blk_q),
      .hit    (wa_hit),
      .aligned(wa_al),
      .offs   (wa_offs),
      .bnum   (wa_bnum)
   );

   bfp_setup_tmr #(
      .SETUP_CYC(SETUP_CYC)
   ) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (st_q == ST_SETUP),
      .done (tmr_done)
   );

   assign buf_wr = (st_q == ST_FILL) && host_we && wa_hit && wa_al;

   bfp_wbuf #(
      .DATA_W   (DATA_W),
      .BUF_WORDS(BUF_WORDS)
   ) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (st_q != ST_FILL),
      .wr_en  (buf_wr),
      .wr_data(host_wdata),
      .rd_idx (idx_q),
      .rd_data(buf_rd),
      .last   (buf_last)
   );

   always_comb begin
      st_d   = st_q;
      blk_d  = blk_q;
      ptr_d  = ptr_q;
      idx_d  = idx_q;
      pf_d   = pf_q;
      verr_d = verr_q;
      lerr_d = lerr_q;
      case (st_q)
         ST_IDLE: begin
            if (host_we && host_wdata[7:0] == CMD_ENTER) begin
               st_d   = ST_ARMED;
               blk_d  = wa_bnum;
               pf_d   = 1'b0;
               verr_d = 1'b0;
               lerr_d = 1'b0;
            end
         end
         ST_ARMED: begin
            if (host_we) begin
               if (host_wdata[7:0] == CMD_CONFIRM && wa_hit && wa_al) begin
                  st_d  = ST_SETUP;
                  ptr_d = {1'b0, wa_offs};
               end else begin
                  st_d = ST_IDLE;
                  pf_d = 1'b1;
               end
            end
         end
         ST_SETUP: begin
            if (tmr_done) begin
               verr_d = !vpp_ok;
               lerr_d = blk_locked;
               st_d   = (!vpp_ok || blk_locked) ? ST_IDLE : ST_FILL;
            end
         end
         ST_FILL: begin
            if (host_we) begin
               if (!wa_hit) begin
                  st_d = ST_IDLE;
                  pf_d = (host_wdata != '1);
               end else if (!wa_al) begin
                  st_d = ST_IDLE;
                  pf_d = 1'b1;
               end else if (buf_last) begin
                  if (ptr_q[BLK_AW]) begin
                     st_d = ST_IDLE;
                     pf_d = 1'b1;
                  end else begin
                     st_d  = ST_PROG;
                     idx_d = '0;
                  end
               end
            end
         end
         ST_PROG: begin
            if (arr_ack) begin
               ptr_d = ptr_q + 1'b1;
               idx_d = idx_q + 1'b1;
               if (idx_q == IDX_LAST) st_d = ST_FILL;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         blk_q  <= '0;
         ptr_q  <= '0;
         idx_q  <= '0;
         pf_q   <= 1'b0;
         verr_q <= 1'b0;
         lerr_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         blk_q  <= blk_d;
         ptr_q  <= ptr_d;
         idx_q  <= idx_d;
         pf_q   <= pf_d;
         verr_q <= verr_d;
         lerr_q <= lerr_d;
      end
   end

   assign mode_on = (st_q == ST_SETUP) || (st_q == ST_FILL) || (st_q == ST_PROG);
   assign status  = {!mode_on, 2'b00, pf_q, verr_q, 1'b0, lerr_q,
                     (st_q == ST_SETUP) || (st_q == ST_PROG)};

   assign rd_hit     = (host_raddr[ADDR_W-1:BLK_AW] == blk_q);
   assign host_rdata = (mode_on && rd_hit) ? DATA_W'(status) : arr_rdata;

   assign arr_req  = (st_q == ST_PROG);
   assign arr_addr = {blk_q, ptr_q[BLK_AW-1:0]};
   assign arr_data = buf_rd;

   // R2
   enter_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status[7]) |-> status[0]);

   // R7
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_req && !arr_ack) |=> (arr_req && $stable(arr_addr) && $stable(arr_data)));

   // R7
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_req && arr_ack) |=> (arr_addr[BLK_AW-1:0] == $past(arr_addr[BLK_AW-1:0]) + 1'b1));

   // R9
   misalign_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FILL && host_we && wa_hit && !wa_al) |=> (status[4] && status[7] && !arr_req));

   // R10
   exit_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FILL && host_we && !wa_hit && host_wdata == '1) |=> (status == 8'h80));

   // R11
   blk_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_wr && buf_last && ptr_q[BLK_AW]) |=> (status[4] && !arr_req));

endmodule

// File: tb/tb_bfp_seq.sv
`timescale 1ns/1ps
module tb_bfp_seq;

   localparam int AW = 10;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_we = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [DW-1:0] host_wdata = '0;
   logic [AW-1:0] host_raddr = '0;
   logic [DW-1:0] host_rdata;
   logic          vpp_ok = 1'b1;
   logic          blk_locked = 1'b0;
   logic [7:0]    status;
   logic          arr_req;
   logic [AW-1:0] arr_addr;
   logic [DW-1:0] arr_data;
   logic          arr_ack;
   logic [DW-1:0] arr_rdata = 16'hA5A5;

   int   total = 0;
   int   bad = 0;
   int   nwr = 0;
   logic fin = 1'b0;
   logic ack_ph = 1'b0;
   logic [DW-1:0] amem [1024];

   always #2 clk = ~clk;

   bfp_seq #(
      .ADDR_W(AW), .DATA_W(DW), .BUF_WORDS(8), .BLK_WORDS(64), .SETUP_CYC(5)
   ) dut (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
      .vpp_ok(vpp_ok), .blk_locked(blk_locked), .status(status),
      .arr_req(arr_req), .arr_addr(arr_addr), .arr_data(arr_data),
      .arr_ack(arr_ack), .arr_rdata(arr_rdata)
   );

   // array model: acknowledges on alternate cycles
   always @(posedge clk) ack_ph <= ~ack_ph;
   assign arr_ack = arr_req & ack_ph;
   always @(posedge clk) begin
      if (arr_req && arr_ack) begin
         amem[arr_addr] <= arr_data;
         nwr <= nwr + 1;
      end
   end

   // {addr, data, status after write, settle cycles, status after settle}
   localparam logic [49:0] VEC [19] = '{
      {10'h088, 16'h0080, 8'h80, 8'd0,  8'h80},
      {10'h088, 16'h00D0, 8'h01, 8'd8,  8'h00},
      {10'h088, 16'h1100, 8'h00, 8'd0,  8'h00},
      {10'h088, 16'h1101, 8'h00, 8'd0,  8'h00},
      {10'h088, 16'h1102, 8'h00, 8'd0,  8'h00},
      {10'h088, 16'h0070, 8'h00, 8'd0,  8'h00},
      {10'h088, 16'h1104, 8'h00, 8'd0,  8'h00},
      {10'h088, 16'h1105, 8'h00, 8'd0,  8'h00},
      {10'h088, 16'h1106, 8'h00, 8'd0,  8'h00},
      {10'h088, 16'h1107, 8'h01, 8'd24, 8'h00},
      {10'h088, 16'h2200, 8'h00, 8'd0,  8'h00},
      {10'h088, 16'h2201, 8'h00, 8'd0,  8'h00},
      {10'h088, 16'h2202, 8'h00, 8'd0,  8'h00},
      {10'h088, 16'h2203, 8'h00, 8'd0,  8'h00},
      {10'h088, 16'h2204, 8'h00, 8'd0,  8'h00},
      {10'h088, 16'hFFFF, 8'h00, 8'd0,  8'h00},
      {10'h088, 16'hFFFF, 8'h00, 8'd0,  8'h00},
      {10'h088, 16'hFFFF, 8'h01, 8'd24, 8'h00},
      {10'h000, 16'hFFFF, 8'h80, 8'd0,  8'h80}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic enter(input logic [AW-1:0] a);
      wr(a, 16'h0080);
      wr(a, 16'h00D0);
      settle(8);
   endtask

   task automatic fill(input logic [AW-1:0] a, input logic [DW-1:0] base);
      for (int i = 0; i < 8; i++) wr(a, base + DW'(i));
      settle(24);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) amem[i] = '0;
      settle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 status", status, 8'h80);
      chk("R1 arr_req", arr_req, 1'b0);
      host_raddr = 10'h088;
      #1 chk("R5 idle passthrough", host_rdata, 16'hA5A5);

      // table-driven session: entry, two buffers, exit (R2 R6 R7 R8 R10)
      for (int v = 0; v < 19; v++) begin
         wr(VEC[v][49:40], VEC[v][39:24]);
         chk("R2/R6/R10 status after write", status, VEC[v][23:16]);
         settle(int'(VEC[v][15:8]));
         chk("R2/R7 status after settle", status, VEC[v][7:0]);
      end
      chk("R7 word count", nwr, 16);
      for (int i = 0; i < 16; i++)
         chk("R7/R8 array word", amem[10'h088 + i], VEC[2 + i][39:24]);
      chk("R8 below start untouched", amem[10'h087], 16'h0000);
      chk("R8 past end untouched", amem[10'h098], 16'h0000);

      // R2 exact setup length
      wr(10'h0C0, 16'h0080);
      wr(10'h0C0, 16'h00D0);
      settle(4);
      chk("R2 still busy", status, 8'h01);
      settle(1);
      chk("R2 ready", status, 8'h00);
      // R5 read redirect
      host_raddr = 10'h0C5;
      #1 chk("R5 in-block status", host_rdata, 16'h0000);
      host_raddr = 10'h005;
      #1 chk("R5 outside passthrough", host_rdata, 16'hA5A5);
      // R9 misaligned write discards buffer
      wr(10'h0C0, 16'h0001);
      wr(10'h0C1, 16'h0002);
      chk("R9 misaligned abort", status, 8'h90);
      settle(20);
      chk("R9 no array write", nwr, 16);
      // R12 error bits cleared by entry
      wr(10'h0C0, 16'h0080);
      chk("R12 cleared", status, 8'h80);
      wr(10'h0C0, 16'h00D0);
      settle(8);
      // R9 outside non-FFFF write
      wr(10'h100, 16'h1234);
      chk("R9 outside abort", status, 8'h90);
      chk("R9 no array write 2", nwr, 16);

      // R3 bad confirm cases
      wr(10'h0C0, 16'h0080);
      wr(10'h0C4, 16'h00D0);
      chk("R3 misaligned confirm", status, 8'h90);
      wr(10'h0C0, 16'h0080);
      wr(10'h100, 16'h00D0);
      chk("R3 other block confirm", status, 8'h90);
      wr(10'h0C0, 16'h0080);
      wr(10'h0C0, 16'h0055);
      chk("R3 wrong command", status, 8'h90);

      // R4 setup checks
      vpp_ok = 1'b0;
      enter(10'h0C0);
      chk("R4 voltage error", status, 8'h88);
      vpp_ok = 1'b1; blk_locked = 1'b1;
      enter(10'h0C0);
      chk("R4 lock error", status, 8'h82);
      vpp_ok = 1'b0;
      enter(10'h0C0);
      chk("R4 both errors", status, 8'h8A);
      vpp_ok = 1'b1; blk_locked = 1'b0;

      // R11 block end
      enter(10'h070);
      chk("R11 entered", status, 8'h00);
      fill(10'h070, 16'h3000);
      fill(10'h070, 16'h3100);
      chk("R11 ready at end", status, 8'h00);
      chk("R11 count", nwr, 32);
      for (int i = 0; i < 8; i++) begin
         chk("R8 end block word a", amem[10'h070 + i], 16'h3000 + DW'(i));
         chk("R8 end block word b", amem[10'h078 + i], 16'h3100 + DW'(i));
      end
      for (int i = 0; i < 8; i++) wr(10'h070, 16'h3200 + DW'(i));
      chk("R11 overrun abort", status, 8'h90);
      settle(20);
      chk("R11 no extra write", nwr, 32);
      chk("R11 no wrap", amem[10'h040], 16'h0000);

      fin = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!fin) begin
         total++;
         bad++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule